// File: doc/BRIEF.md
# Write-Protection Command Sequence Decoder

This block sits beside a byte-wide nonvolatile array and watches the synchronous write bus that feeds it. Each write carries an address, a data byte and a one-cycle strobe. The block looks for fixed command keys: exact data values written to two magic addresses. It uses them to turn a protect flag on or off and to request a full-array erase. The array controller uses `wr_permit` to decide whether the byte on the bus this cycle may be stored. It uses `erase_req` to start filling every byte with FFh.

There are three keys, and each is a run of writes. The lock key is AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h. The unlock key is six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h. The erase key is the unlock key with a final byte of 10h. Only the low 15 address bits take part in the comparison.

After the lock key the flag is set. While the flag is set, an ordinary write is refused unless it arrives after a lock key and before the next load-window expiry. Those writes are accepted and the flag stays set. The flag is cleared only by power-on reset or by the unlock key. A separate synchronous soft reset clears key progress but keeps the flag.

Top module: `keyseq_guard`

## Requirements
- R1: After power-on reset (`por_n` low), `prot_state`=0, `status`=00h and `erase_req`=0.
- R2: While `prot_state` is 0, every write has `wr_permit`=1 in its own cycle.
- R3: Three consecutive writes AAh@5555h, 55h@2AAAh, A0h@5555h set `prot_state` to 1 from the clock edge that takes the third write. `status` bit 0 equals `prot_state` and `status` bits 7..1 are 0.
- R4: While `prot_state` is 1 and no lock key has been completed since the last window expiry, a write gets `wr_permit`=0.
- R5: While `prot_state` is 1, writes that follow a completed lock key get `wr_permit`=1 and leave `prot_state` at 1, until a `win_expire` pulse. From the `win_expire` cycle on, writes get `wr_permit`=0 again.
- R6: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clear `prot_state` from the edge that takes the sixth write.
- R7: The same six writes with a last byte of 10h raise `erase_req` for exactly one cycle, right after the edge that takes the sixth write, and leave `prot_state` unchanged.
- R8: A write that does not match the next key step returns the matcher to idle. If that write is AAh@5555h, it counts as the first step of a new key.
- R9: A `win_expire` pulse discards partial key progress, so the remaining steps of an interrupted key have no effect.
- R10: Address bits 16..15 are ignored when matching 5555h and 2AAAh.
- R11: `srst_n` low discards key progress and any open lock-key write window, and never changes `prot_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset; the only reset of the protect flag |
| srst_n | input | 1 | Synchronous active-low soft reset of key progress and write window |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 17 | Write byte address |
| wr_data | input | 8 | Write data byte |
| win_expire | input | 1 | Pulse marking the end of the current page-load window |
| prot_state | output | 1 | Protect flag, 1 = protected |
| status | output | 8 | Status byte, bit 0 = protect flag, other bits 0 |
| wr_permit | output | 1 | The write in this cycle may reach the array |
| erase_req | output | 1 | One-cycle full-array erase request |

## Verification
The decoder is driven with all three complete keys, with the lock key seen through aliased upper address bits, and with broken keys: a wrong third byte, a doubled first byte, a window expiry in mid-key, and a soft reset in mid-key. The wrong byte and the doubled first byte tell a matcher that restarts on AAh@5555h apart from one that only resets. The mid-key expiry shows whether progress really spans only one load window. Plain writes are tried in each protection state, inside and outside an open lock-key window. This separates the unprotected pass-through, the post-key acceptance and the refusal paths, and shows that the soft reset closes the window but keeps the flag.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_X3   = 3'd3,
    ST_X4   = 3'd4,
    ST_X5   = 3'd5
  } step_e;

  localparam logic [7:0] KD_FIRST  = 8'hAA;
  localparam logic [7:0] KD_SECOND = 8'h55;
  localparam logic [7:0] KD_LOCK   = 8'hA0;
  localparam logic [7:0] KD_EXTEND = 8'h80;
  localparam logic [7:0] KD_UNLOCK = 8'h20;
  localparam logic [7:0] KD_WIPE   = 8'h10;
endpackage

// File: rtl/keyseq_match.sv
module keyseq_match
  import keyseq_pkg::*;
#(
  parameter int AW    = 17,
  parameter int CMP_W = 15,
  parameter logic [CMP_W-1:0] ADDR_A = 15'h5555,
  parameter logic [CMP_W-1:0] ADDR_B = 15'h2AAA
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          flush,
  input  logic          blk,
  input  step_e         step_q,
  output step_e         step_nxt,
  output logic          ev_lock,
  output logic          ev_unlock,
  output logic          ev_wipe
);
  localparam int CW = (CMP_W < AW) ? CMP_W : AW;

  logic [CW-1:0] addr_cmp;
  logic          hit_a, hit_b, k_aa, k_55;
  step_e         cur, restart;

  generate
    if (CW == AW) begin : g_full
      assign addr_cmp = wr_addr;
    end else begin : g_part
      assign addr_cmp = wr_addr[CW-1:0];
    end
  endgenerate

  always_comb begin
    hit_a     = (addr_cmp == ADDR_A[CW-1:0]);
    hit_b     = (addr_cmp == ADDR_B[CW-1:0]);
    k_aa      = hit_a && (wr_data == KD_FIRST);
    k_55      = hit_b && (wr_data == KD_SECOND);
    restart   = k_aa ? ST_K1 : ST_IDLE;
    cur       = flush ? ST_IDLE : step_q;
    step_nxt  = cur;
    ev_lock   = 1'b0;
    ev_unlock = 1'b0;
    ev_wipe   = 1'b0;
    if (wr_en && !blk) begin
      case (cur)
        ST_IDLE: step_nxt = restart;
        ST_K1:   step_nxt = k_55 ? ST_K2 : restart;
        ST_K2: begin
          if (hit_a && wr_data == KD_LOCK) begin
            ev_lock  = 1'b1;
            step_nxt = ST_IDLE;
          end else if (hit_a && wr_data == KD_EXTEND) begin
            step_nxt = ST_X3;
          end else begin
            step_nxt = restart;
          end
        end
        ST_X3:   step_nxt = k_aa ? ST_X4 : ST_IDLE;
        ST_X4:   step_nxt = k_55 ? ST_X5 : restart;
        ST_X5: begin
          if (hit_a && wr_data == KD_UNLOCK) begin
            ev_unlock = 1'b1;
            step_nxt  = ST_IDLE;
          end else if (hit_a && wr_data == KD_WIPE) begin
            ev_wipe  = 1'b1;
            step_nxt = ST_IDLE;
          end else begin
            step_nxt = restart;
          end
        end
        default: step_nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keyseq_track.sv
module keyseq_track
  import keyseq_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  srst_n,
  input  step_e step_nxt,
  output step_e step_q
);
  step_e step_d;

  always_comb begin
    step_d = srst_n ? step_nxt : ST_IDLE;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/prot_keeper.sv
module prot_keeper (
  input  logic clk,
  input  logic por_n,
  input  logic srst_n,
  input  logic win_expire,
  input  logic ev_lock,
  input  logic ev_unlock,
  input  logic ev_wipe,
  output logic prot_q,
  output logic open_q,
  output logic wipe_q
);
  logic prot_d, prot_ce, open_d, open_ce;

  always_comb begin
    prot_ce = ev_lock || ev_unlock;
    prot_d  = ev_lock;
    open_ce = !srst_n || win_expire || ev_lock;
    open_d  = srst_n && ev_lock;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prot_q <= 1'b0;
      open_q <= 1'b0;
      wipe_q <= 1'b0;
    end else begin
      if (prot_ce) prot_q <= prot_d;
      if (open_ce) open_q <= open_d;
      wipe_q <= ev_wipe;
    end
  end
endmodule

// File: rtl/keyseq_guard.sv
module keyseq_guard
  import keyseq_pkg::*;
#(
  parameter int AW    = 17,
  parameter int CMP_W = 15
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          srst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          win_expire,
  output logic          prot_state,
  output logic [7:0]    status,
  output logic          wr_permit,
  output logic          erase_req
);
  step_e step_q, step_nxt;
  logic  ev_lock, ev_unlock, ev_wipe;
  logic  prot_q, open_q, wipe_q;

  keyseq_match #(.AW(AW), .CMP_W(CMP_W)) u_match (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flush     (win_expire),
    .blk       (!srst_n),
    .step_q    (step_q),
    .step_nxt  (step_nxt),
    .ev_lock   (ev_lock),
    .ev_unlock (ev_unlock),
    .ev_wipe   (ev_wipe)
  );

  keyseq_track u_track (
    .clk      (clk),
    .por_n    (por_n),
    .srst_n   (srst_n),
    .step_nxt (step_nxt),
    .step_q   (step_q)
  );

  prot_keeper u_keep (
    .clk        (clk),
    .por_n      (por_n),
    .srst_n     (srst_n),
    .win_expire (win_expire),
    .ev_lock    (ev_lock),
    .ev_unlock  (ev_unlock),
    .ev_wipe    (ev_wipe),
    .prot_q     (prot_q),
    .open_q     (open_q),
    .wipe_q     (wipe_q)
  );

  always_comb begin
    prot_state = prot_q;
    status     = {7'b0, prot_q};
    erase_req  = wipe_q;
    wr_permit  = wr_en && (!prot_q || (open_q && !win_expire && srst_n));
  end
endmodule

// File: rtl/keyseq_guard_chk.sv
module keyseq_guard_chk #(
  parameter int AW    = 17,
  parameter int CMP_W = 15
) (
  input logic          clk,
  input logic          por_n,
  input logic          srst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          prot_state,
  input logic          wr_permit,
  input logic          erase_req
);
  logic at_a;
  assign at_a = (wr_addr[CMP_W-1:0] == 15'h5555);

  AST_LOCK_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(prot_state) |-> $past(wr_en && at_a && wr_data == 8'hA0)); // R3
  AST_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(prot_state) |-> $past(wr_en && at_a && wr_data == 8'h20)); // R6
  AST_ERASE_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
    erase_req |-> $past(wr_en && at_a && wr_data == 8'h10)); // R7
  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    erase_req |=> !erase_req); // R7
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !prot_state) |-> wr_permit); // R2
  AST_PERMIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    wr_permit |-> wr_en); // R4
  AST_SOFT_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    !srst_n |=> $stable(prot_state)); // R11
endmodule

bind keyseq_guard keyseq_guard_chk #(.AW(AW), .CMP_W(CMP_W)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .srst_n     (srst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .prot_state (prot_state),
  .wr_permit  (wr_permit),
  .erase_req  (erase_req)
);

// File: tb/tb_keyseq_guard.sv
module tb_keyseq_guard;
  logic        clk = 1'b0;
  logic        por_n, srst_n, wr_en, win_expire;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;
  logic        prot_state, wr_permit, erase_req;
  logic [7:0]  status;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  keyseq_guard dut (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .win_expire(win_expire),
    .prot_state(prot_state), .status(status), .wr_permit(wr_permit),
    .erase_req(erase_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, output bit p);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1 p = wr_permit;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expire();
    @(negedge clk); win_expire = 1'b1;
    @(negedge clk); win_expire = 1'b0;
  endtask

  task automatic key3(input logic [16:0] ha, input logic [16:0] hb);
    bit p;
    wr(ha, 8'hAA, p); wr(hb, 8'h55, p); wr(ha, 8'hA0, p);
  endtask

  task automatic key6(input logic [7:0] last);
    bit p;
    wr(17'h05555, 8'hAA, p); wr(17'h02AAA, 8'h55, p); wr(17'h05555, 8'h80, p);
    wr(17'h05555, 8'hAA, p); wr(17'h02AAA, 8'h55, p); wr(17'h05555, last, p);
  endtask

  task automatic t_reset();
    chk(prot_state == 0, "R1 prot", prot_state, 0);
    chk(status == 8'h00, "R1 status", status, 0);
    chk(erase_req == 0, "R1 erase", erase_req, 0);
  endtask

  task automatic t_open();
    bit p;
    wr(17'h00123, 8'h3C, p); chk(p == 1, "R2 plain", p, 1);
    wr(17'h1FFFF, 8'hAA, p); chk(p == 1, "R2 top addr", p, 1);
  endtask

  task automatic t_restart();
    bit p;
    wr(17'h05555, 8'hAA, p); wr(17'h02AAA, 8'h55, p);
    wr(17'h05555, 8'h00, p); wr(17'h05555, 8'hA0, p);
    chk(prot_state == 0, "R8 broken key", prot_state, 0);
    expire();
    wr(17'h05555, 8'hAA, p); key3(17'h05555, 17'h02AAA);
    chk(prot_state == 1, "R8 restart on AA", prot_state, 1);
    chk(status == 8'h01, "R3 status", status, 8'h01);
    expire();
  endtask

  task automatic t_blocked();
    bit p;
    wr(17'h00400, 8'h11, p); chk(p == 0, "R4 refused", p, 0);
    chk(prot_state == 1, "R4 flag", prot_state, 1);
  endtask

  task automatic t_window();
    bit p;
    key3(17'h05555, 17'h02AAA);
    wr(17'h00080, 8'h5A, p); chk(p == 1, "R5 after key", p, 1);
    wr(17'h00081, 8'h5B, p); chk(p == 1, "R5 second byte", p, 1);
    chk(prot_state == 1, "R5 flag kept", prot_state, 1);
    expire();
    wr(17'h00082, 8'h5C, p); chk(p == 0, "R5 after expiry", p, 0);
  endtask

  task automatic t_soft();
    bit p;
    wr(17'h05555, 8'hAA, p); wr(17'h02AAA, 8'h55, p);
    @(negedge clk); srst_n = 1'b0; @(negedge clk); srst_n = 1'b1;
    wr(17'h05555, 8'hA0, p);
    wr(17'h00010, 8'h77, p); chk(p == 0, "R11 progress lost", p, 0);
    key3(17'h05555, 17'h02AAA);
    @(negedge clk); srst_n = 1'b0; @(negedge clk); srst_n = 1'b1;
    wr(17'h00011, 8'h78, p); chk(p == 0, "R11 window closed", p, 0);
    chk(prot_state == 1, "R11 flag kept", prot_state, 1);
  endtask

  task automatic t_unlock();
    bit p;
    key6(8'h20);
    chk(prot_state == 0, "R6 cleared", prot_state, 0);
    wr(17'h00300, 8'h01, p); chk(p == 1, "R6 writes pass", p, 1);
  endtask

  task automatic t_expire();
    bit p;
    wr(17'h05555, 8'hAA, p); wr(17'h02AAA, 8'h55, p);
    expire();
    wr(17'h05555, 8'hA0, p);
    chk(prot_state == 0, "R9 interrupted", prot_state, 0);
  endtask

  task automatic t_alias();
    key3(17'h1D555, 17'h1AAAA);
    chk(prot_state == 1, "R10 upper bits", prot_state, 1);
    expire();
  endtask

  task automatic t_erase();
    chk(erase_req == 0, "R7 idle", erase_req, 0);
    key6(8'h10);
    chk(erase_req == 1, "R7 pulse", erase_req, 1);
    chk(prot_state == 1, "R7 flag kept", prot_state, 1);
    @(negedge clk);
    chk(erase_req == 0, "R7 one cycle", erase_req, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; srst_n = 1'b1; wr_en = 1'b0; win_expire = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open();
    t_restart();
    t_blocked();
    t_window();
    t_soft();
    t_unlock();
    t_expire();
    t_alias();
    t_erase();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule